// File: doc/BRIEF.md
# Bank Mapping Register File

This block holds a small file of page registers that widen a 16-bit logical address into a 21-bit physical address. The logical space is split into eight windows of 8192 bytes each. The top three logical address bits pick one of the eight registers. That register's 8-bit contents become the upper bits of the physical address, and the low 13 logical bits pass through unchanged. The translation is purely combinational, so an address issued in a cycle is translated in the same cycle.

Software loads the registers through a broadcast write port. One 8-bit value is written, in a single clock edge, into every register whose bit is set in an 8-bit select mask. A separate read port takes its own mask and returns the selected register. When that read mask is all zeros, the port instead returns a held copy of the last value that a write actually stored. A write whose mask is zero stores nothing and leaves that held copy as it was.

Top module: `bank_map_top`

## Requirements
- R1: Reset is synchronous and active low. After reset every mapping register reads 0 and the held last-written copy reads 0.
- R2: At a clock edge with `wr_en`=1, every register i whose `wr_sel` bit i is 1 takes `wr_data`. The new value is visible from the next cycle.
- R3: At that same edge, a register whose `wr_sel` bit is 0 keeps its value.
- R4: A write with `wr_en`=1 and `wr_sel`=0 changes no mapping register.
- R5: A write with `wr_sel`=0 does not change the held last-written copy.
- R6: `rd_sel`=0 returns the `wr_data` of the most recent write that had `wr_en`=1 and a nonzero `wr_sel`.
- R7: A one-hot `rd_sel` with bit i set returns register i, in the same cycle.
- R8: An `rd_sel` with several bits set returns the bitwise OR of the selected registers.
- R9: `phys_addr` = {register[`log_addr`[15:13]], `log_addr`[12:0]}, combinationally.
- R10: With `wr_en`=0, no register and not the held copy changes, whatever `wr_sel` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 8 | Write select mask; bit i targets register i |
| wr_data | input | 8 | Value broadcast to the selected registers |
| rd_sel | input | 8 | Read select mask; zero selects the held last-written copy |
| rd_data | output | 8 | Read result |
| log_addr | input | 16 | Logical address to translate |
| phys_addr | output | 21 | Translated physical address |

## Verification
The assertions rely on `wr_sel` and `wr_data` being stable around the rising edge whenever `wr_en` is high. They judge each register and the held copy only from their value one cycle after a write strobe. The bench drives every input on the falling edge and samples the combinational outputs shortly after it. Each write is held for exactly one rising edge, so every strobe maps to a single known update. The held-copy checks use writes with deliberately different data, so a zero-mask write or an idle strobe that leaked into the copy would show up on `rd_data`.

// File: rtl/bank_map_pkg.sv
// Shared sizing for the bank mapping register file.
// Assumes the page-offset width plus the select width equals the logical address width.
package bank_map_pkg;
    localparam int NUM_BANKS = 8;
    localparam int PAGE_W    = 8;
    localparam int OFFS_W    = 13;
endpackage

// File: rtl/bank_map_regs.sv
// Mapping register array with a mask-broadcast write and a last-written shadow.
// Assumes: wr_sel is one bit per register, and wr_data is stable at the edge.
module bank_map_regs
    import bank_map_pkg::*;
#(
    parameter int N_BANKS = NUM_BANKS,
    parameter int DW      = PAGE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [N_BANKS-1:0]         wr_sel,
    input  logic [DW-1:0]              wr_data,
    output logic [N_BANKS-1:0][DW-1:0] bank_q,
    output logic [DW-1:0]              shadow_q
);
    logic any_sel;
    assign any_sel = |wr_sel;

    for (genvar i = 0; i < N_BANKS; i++) begin : g_bank
        // Load register i when it is selected by a write strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[i] <= '0;
            else if (wr_en && wr_sel[i])
                bank_q[i] <= wr_data;
        end

        // R2
        bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel[i]) |=> (bank_q[i] == $past(wr_data)));

        // R3 R4 R10
        bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_sel[i]) |=> $stable(bank_q[i]));
    end

    // Remember the value of the last write that reached at least one register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (wr_en && any_sel)
            shadow_q <= wr_data;
    end

    // R5 R10
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_sel != '0)) |=> $stable(shadow_q));

    // R6
    shadow_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel != '0)) |=> (shadow_q == $past(wr_data)));
endmodule

// File: rtl/bank_map_rdmux.sv
// Read port: OR of all registers picked by the read mask, or the shadow when the mask is zero.
// Assumes: a one-hot mask is the normal case; several bits give a defined OR.
module bank_map_rdmux
    import bank_map_pkg::*;
#(
    parameter int N_BANKS = NUM_BANKS,
    parameter int DW      = PAGE_W
) (
    input  logic [N_BANKS-1:0]         rd_sel,
    input  logic [N_BANKS-1:0][DW-1:0] bank_q,
    input  logic [DW-1:0]              shadow_q,
    output logic [DW-1:0]              rd_data
);
    // Merge selected registers, falling back to the shadow for an empty mask.
    always_comb begin
        logic [DW-1:0] acc;
        acc = '0;
        for (int i = 0; i < N_BANKS; i++)
            if (rd_sel[i]) acc = acc | bank_q[i];
        rd_data = (rd_sel == '0) ? shadow_q : acc;
    end
endmodule

// File: rtl/bank_map_xlate.sv
// Combinational logical-to-physical translation via the page registers.
// Assumes: N_BANKS is a power of two, so every select value addresses a register.
module bank_map_xlate
    import bank_map_pkg::*;
#(
    parameter int N_BANKS = NUM_BANKS,
    parameter int DW      = PAGE_W,
    parameter int OW      = OFFS_W
) (
    input  logic [N_BANKS-1:0][DW-1:0]         bank_q,
    input  logic [OW+$clog2(N_BANKS)-1:0]      log_addr,
    output logic [DW+OW-1:0]                   phys_addr
);
    localparam int SEL_W = $clog2(N_BANKS);
    localparam int LAW   = OW + SEL_W;

    logic [SEL_W-1:0] page_idx;

    // Pick the window register and splice it above the page offset.
    always_comb begin
        page_idx  = log_addr[LAW-1:OW];
        phys_addr = {bank_q[page_idx], log_addr[OW-1:0]};
    end
endmodule

// File: rtl/bank_map_top.sv
// Top of the bank mapping register file: register array, read port and translator.
// Assumes: inputs are synchronous to clk; reset is synchronous active low.
module bank_map_top
    import bank_map_pkg::*;
#(
    parameter int N_BANKS = NUM_BANKS,
    parameter int DW      = PAGE_W,
    parameter int OW      = OFFS_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [N_BANKS-1:0]                wr_sel,
    input  logic [DW-1:0]                     wr_data,
    input  logic [N_BANKS-1:0]                rd_sel,
    output logic [DW-1:0]                     rd_data,
    input  logic [OW+$clog2(N_BANKS)-1:0]     log_addr,
    output logic [DW+OW-1:0]                  phys_addr
);
    logic [N_BANKS-1:0][DW-1:0] bank_q;
    logic [DW-1:0]              shadow_q;

    bank_map_regs #(.N_BANKS(N_BANKS), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .bank_q   (bank_q),
        .shadow_q (shadow_q)
    );

    bank_map_rdmux #(.N_BANKS(N_BANKS), .DW(DW)) u_rdmux (
        .rd_sel   (rd_sel),
        .bank_q   (bank_q),
        .shadow_q (shadow_q),
        .rd_data  (rd_data)
    );

    bank_map_xlate #(.N_BANKS(N_BANKS), .DW(DW), .OW(OW)) u_xlate (
        .bank_q    (bank_q),
        .log_addr  (log_addr),
        .phys_addr (phys_addr)
    );
endmodule

// File: tb/bank_map_top_test.sv
// Directed bench for bank_map_top; one task per scenario, with a reference model.
module bank_map_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_sel = '0;
    logic [7:0]  rd_data;
    logic [15:0] log_addr = '0;
    logic [20:0] phys_addr;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [8];
    logic [7:0] model_shadow;

    bank_map_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .log_addr(log_addr), .phys_addr(phys_addr)
    );

    always #5 clk = ~clk;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic en, input logic [7:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = en; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        if (en && sel != 0) begin
            for (int i = 0; i < 8; i++) if (sel[i]) model[i] = data;
            model_shadow = data;
        end
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < 8; i++) begin
            rd_sel = 8'(1 << i); #1;
            check({24'd0, rd_data}, {24'd0, model[i]}, req);
        end
        rd_sel = '0; #1;
        check({24'd0, rd_data}, {24'd0, model_shadow}, req);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 8; i++) model[i] = '0;
        model_shadow = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        read_all("R1");
        log_addr = 16'hE123; #1;
        check({11'd0, phys_addr}, {11'd0, 8'h00, 13'h0123}, "R1");
    endtask

    task automatic t_broadcast();
        do_write(1'b1, 8'h41, 8'hA5);
        read_all("R2 R3 R7 R6");
    endtask

    task automatic t_zero_mask();
        do_write(1'b1, 8'h00, 8'h3C);
        read_all("R4 R5");
    endtask

    task automatic t_idle();
        do_write(1'b0, 8'hFF, 8'h77);
        read_all("R10");
    endtask

    task automatic t_multi_read();
        do_write(1'b1, 8'hFF, 8'h12);
        do_write(1'b1, 8'h80, 8'hF0);
        rd_sel = 8'h81; #1;
        check({24'd0, rd_data}, {24'd0, 8'hF2}, "R8");
        rd_sel = 8'hFF; #1;
        check({24'd0, rd_data}, {24'd0, 8'hF2}, "R8");
        rd_sel = 8'h06; #1;
        check({24'd0, rd_data}, {24'd0, 8'h12}, "R8");
        rd_sel = '0; #1;
        check({24'd0, rd_data}, {24'd0, 8'hF0}, "R6");
    endtask

    task automatic t_xlate();
        for (int i = 0; i < 8; i++) do_write(1'b1, 8'(1 << i), 8'(8'hF8 - 8'(i * 3)));
        read_all("R2 R7");
        for (int i = 0; i < 8; i++) begin
            logic [15:0] la;
            la = {3'(i), 13'(13'h1ABC ^ 13'(i * 37))};
            log_addr = la; #1;
            check({11'd0, phys_addr}, {11'd0, model[i], la[12:0]}, "R9");
        end
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_broadcast();
        t_zero_mask();
        t_idle();
        t_multi_read();
        t_xlate();
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule